// File: doc/BRIEF.md
# Call/Return Stack Frame Sequencer

This block carries out subroutine linkage for a 32-bit processor whose register 0 serves as the frame pointer and register 1 as the stack pointer. It takes one command at a time. A call lays down a three-word frame below the stack pointer and then jumps to the target. The frame holds a reserved static-chain word, the return address and the caller's frame pointer. A return walks that frame back up, restoring the caller's frame pointer and program counter.

The surrounding pipeline presents the command along with the current PC, SP and FP. For calls it also presents the target, which is the 32-bit immediate for the absolute form and the named register's value for the register form. The sequencer then works through a word-wide memory request/response port, one access at a time. When it finishes, it raises `done` for one cycle with the updated SP, FP and PC on its outputs.

Top module: `frame_seq`

## Requirements
- R1: After reset the block is idle: `mem_req` and `done` are low and `new_sp`, `new_fp` and `new_pc` are zero.
- R2: A call (`cmd_kind` 2'b00 absolute, 2'b01 register) makes its first memory access a write to address SP − 8.
- R3: The data of that first write is the return address: PC + 6 for the absolute form and PC + 2 for the register form.
- R4: The second access of a call writes the caller's FP to address SP − 12. At completion both `new_sp` and `new_fp` equal SP − 12.
- R5: At call completion `new_pc` equals the `target` value captured with the command, for both call forms.
- R6: A return (`cmd_kind` 2'b10) first reads the word at address FP, and that word becomes `new_fp`.
- R7: A return's second access reads address FP + 4, and that word becomes `new_pc`. At completion `new_sp` is FP + 12, which skips the static-chain word.
- R8: A memory request holds its address, direction and write data stable until `mem_ack` is seen in the same cycle. No later access starts before that.
- R9: `done` is high for exactly one cycle, the cycle after the final access is acknowledged, and no request is active in that cycle.
- R10: A command presented while a sequence is in progress (including the `done` cycle) is ignored. Kind 2'b11 is ignored at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 00 absolute call, 01 register call, 10 return, 11 ignored |
| cur_pc | input | 32 | PC of the call instruction |
| cur_sp | input | 32 | Current stack pointer |
| cur_fp | input | 32 | Current frame pointer |
| target | input | 32 | Call destination (immediate or register value) |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| new_sp | output | 32 | Updated stack pointer |
| new_fp | output | 32 | Updated frame pointer |
| new_pc | output | 32 | Updated program counter |
| done | output | 1 | One-cycle completion pulse |

## Verification
A command sampled at a clock edge puts its first request on the port in the following cycle. Each request then lasts one cycle more than the acknowledge delay the bench chooses, and `done` is due exactly one cycle after the edge that samples the last acknowledge. The bench keeps an ordered queue of expected accesses plus a one-cycle "completion due" flag. On every falling edge it compares the live request with the head of the queue and `done` with the flag, and it checks the result registers only in the flagged cycle. Acknowledge delays rotate through 0 to 3 cycles, so both back-to-back and stalled accesses are covered.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_PUSH_RA,
        FS_PUSH_FP,
        FS_POP_FP,
        FS_POP_PC,
        FS_DONE
    } fs_state_e;

    typedef enum logic [1:0] {
        CK_CALL_IMM = 2'b00,
        CK_CALL_REG = 2'b01,
        CK_RETURN   = 2'b10,
        CK_RSVD     = 2'b11
    } cmd_kind_e;

endpackage

// File: rtl/frame_seq_link.sv
module frame_seq_link #(
    parameter int XLEN    = 32,
    parameter int ABS_LEN = 6,
    parameter int REG_LEN = 2
) (
    input  logic            is_abs,
    input  logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] ret_addr
);
    localparam logic [XLEN-1:0] ABS_STEP = XLEN'(ABS_LEN);
    localparam logic [XLEN-1:0] REG_STEP = XLEN'(REG_LEN);

    // Return point lies just past the call instruction; length depends on form.
    always_comb begin
        ret_addr = pc + (is_abs ? ABS_STEP : REG_STEP);
    end
endmodule

// File: rtl/frame_seq_port.sv
module frame_seq_port
    import frame_seq_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  fs_state_e       st,
    input  logic [XLEN-1:0] sp,
    input  logic [XLEN-1:0] fp,
    input  logic [XLEN-1:0] ra,
    output logic            req,
    output logic            we,
    output logic [XLEN-1:0] addr,
    output logic [XLEN-1:0] wdata
);
    // Every stack access is addressed by the working stack pointer.
    always_comb begin
        req   = 1'b0;
        we    = 1'b0;
        wdata = '0;
        addr  = sp;
        unique case (st)
            FS_PUSH_RA: begin req = 1'b1; we = 1'b1; wdata = ra; end
            FS_PUSH_FP: begin req = 1'b1; we = 1'b1; wdata = fp; end
            FS_POP_FP:  begin req = 1'b1; end
            FS_POP_PC:  begin req = 1'b1; end
            default:    begin end
        endcase
    end
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ABS_LEN = 6,
    parameter int REG_LEN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_kind,
    input  logic [XLEN-1:0] cur_pc,
    input  logic [XLEN-1:0] cur_sp,
    input  logic [XLEN-1:0] cur_fp,
    input  logic [XLEN-1:0] target,
    output logic            mem_req,
    output logic            mem_we,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] new_sp,
    output logic [XLEN-1:0] new_fp,
    output logic [XLEN-1:0] new_pc,
    output logic            done
);
    localparam int              WORD_BYTES = XLEN / 8;
    localparam logic [XLEN-1:0] ONE_WORD   = XLEN'(WORD_BYTES);
    localparam logic [XLEN-1:0] TWO_WORDS  = XLEN'(2 * WORD_BYTES);

    typedef struct packed {
        fs_state_e       st;
        logic [XLEN-1:0] sp;
        logic [XLEN-1:0] fp;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] tgt;
        logic [XLEN-1:0] ra;
    } seq_regs_t;

    seq_regs_t r_q, r_d;
    logic [XLEN-1:0] link_ra;
    cmd_kind_e       kind;

    assign kind = cmd_kind_e'(cmd_kind);

    frame_seq_link #(
        .XLEN    (XLEN),
        .ABS_LEN (ABS_LEN),
        .REG_LEN (REG_LEN)
    ) u_link (
        .is_abs   (kind == CK_CALL_IMM),
        .pc       (cur_pc),
        .ret_addr (link_ra)
    );

    frame_seq_port #(.XLEN(XLEN)) u_port (
        .st    (r_q.st),
        .sp    (r_q.sp),
        .fp    (r_q.fp),
        .ra    (r_q.ra),
        .req   (mem_req),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            FS_IDLE: begin
                if (cmd_valid) begin
                    unique case (kind)
                        CK_CALL_IMM, CK_CALL_REG: begin
                            r_d.sp  = cur_sp - TWO_WORDS;
                            r_d.fp  = cur_fp;
                            r_d.pc  = cur_pc;
                            r_d.ra  = link_ra;
                            r_d.tgt = target;
                            r_d.st  = FS_PUSH_RA;
                        end
                        CK_RETURN: begin
                            r_d.sp = cur_fp;
                            r_d.fp = cur_fp;
                            r_d.pc = cur_pc;
                            r_d.st = FS_POP_FP;
                        end
                        default: begin end
                    endcase
                end
            end
            FS_PUSH_RA: if (mem_ack) begin
                r_d.sp = r_q.sp - ONE_WORD;
                r_d.st = FS_PUSH_FP;
            end
            FS_PUSH_FP: if (mem_ack) begin
                r_d.fp = r_q.sp;
                r_d.pc = r_q.tgt;
                r_d.st = FS_DONE;
            end
            FS_POP_FP: if (mem_ack) begin
                r_d.fp = mem_rdata;
                r_d.sp = r_q.sp + ONE_WORD;
                r_d.st = FS_POP_PC;
            end
            FS_POP_PC: if (mem_ack) begin
                r_d.pc = mem_rdata;
                r_d.sp = r_q.sp + TWO_WORDS;
                r_d.st = FS_DONE;
            end
            default: r_d.st = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: FS_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign new_sp = r_q.sp;
    assign new_fp = r_q.fp;
    assign new_pc = r_q.pc;
    assign done   = (r_q.st == FS_DONE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req); // R9

    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we && mem_ack |=>
            (mem_req && mem_we && mem_addr == $past(mem_addr) - ONE_WORD) || (done && new_fp == new_sp)); // R4

    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_we && mem_ack |=>
            (mem_req && !mem_we && mem_addr == $past(mem_addr) + ONE_WORD) ||
            (done && new_sp == $past(mem_addr) + TWO_WORDS)); // R7

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !mem_req); // R10
endmodule

// File: tb/frame_seq_test.sv
module frame_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'b00;
    logic [31:0] cur_pc = '0, cur_sp = '0, cur_fp = '0, target = '0;
    logic        mem_req, mem_we, mem_ack = 1'b0, done;
    logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
    logic [31:0] new_sp, new_fp, new_pc;

    always #2.5 clk = ~clk;

    frame_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_fp(cur_fp), .target(target),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .new_sp(new_sp), .new_fp(new_fp), .new_pc(new_pc), .done(done)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit mon_on = 0;
    bit due_done = 0;
    int wait_left = 0;
    int wi = 0;
    int waits [4] = '{0, 2, 1, 3};

    logic [31:0] mem [logic [31:0]];
    logic [31:0] q_addr [$];
    logic [31:0] q_data [$];
    bit          q_we [$];
    string       q_tag [$];

    logic [31:0] m_sp, m_fp, m_pc;
    logic [31:0] e_sp, e_fp, e_pc;
    string       e_tag;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Reference model and memory responder, evaluated every cycle.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            chk(1'b0, "watchdog", "cycles", 32'(cyc), 32'd20000);
            finish_run();
        end
        if (mon_on) begin
            chk(done === due_done, "R9", "done timing", {31'd0, done}, {31'd0, due_done});
            if (due_done) begin
                chk(new_sp === e_sp, e_tag, "new_sp", new_sp, e_sp);
                chk(new_fp === e_fp, e_tag, "new_fp", new_fp, e_fp);
                chk(new_pc === e_pc, e_tag, "new_pc", new_pc, e_pc);
                chk(mem_req === 1'b0, "R9", "req during done", {31'd0, mem_req}, 32'd0);
            end
            due_done = 0;
            mem_ack = 1'b0;
            if (mem_req) begin
                if (q_addr.size() == 0) begin
                    chk(1'b0, "R10", "unexpected access", mem_addr, 32'hxxxxxxxx);
                end else begin
                    chk(mem_addr === q_addr[0], q_tag[0], "address", mem_addr, q_addr[0]);
                    chk(mem_we === q_we[0], "R8", "direction", {31'd0, mem_we}, {31'd0, q_we[0]});
                    if (q_we[0])
                        chk(mem_wdata === q_data[0], q_tag[0], "write data", mem_wdata, q_data[0]);
                    if (wait_left > 0) begin
                        wait_left--;
                    end else begin
                        mem_ack = 1'b1;
                        if (mem_we) mem[mem_addr] = mem_wdata;
                        else mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                        void'(q_addr.pop_front());
                        void'(q_data.pop_front());
                        void'(q_we.pop_front());
                        void'(q_tag.pop_front());
                        wait_left = waits[wi % 4];
                        wi++;
                        if (q_addr.size() == 0) due_done = 1;
                    end
                end
            end
        end
    end

    task automatic push_exp(input logic [31:0] a, input bit w, input logic [31:0] d, input string t);
        q_addr.push_back(a); q_we.push_back(w); q_data.push_back(d); q_tag.push_back(t);
    endtask

    // kind: 0 absolute call, 1 register call, 2 return. noise drives commands while busy.
    task automatic run_cmd(input logic [1:0] kind, input logic [31:0] pc,
                           input logic [31:0] tgt, input bit noise);
        logic [31:0] ra, s1, s2;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = kind; cur_pc = pc;
        cur_sp = m_sp; cur_fp = m_fp; target = tgt;
        if (kind == 2'b10) begin
            push_exp(m_fp, 1'b0, 32'h0, "R6");
            push_exp(m_fp + 32'd4, 1'b0, 32'h0, "R7");
            e_fp = mem.exists(m_fp) ? mem[m_fp] : 32'h0;
            e_pc = mem.exists(m_fp + 32'd4) ? mem[m_fp + 32'd4] : 32'h0;
            e_sp = m_fp + 32'd12;
            e_tag = "R6/R7";
        end else begin
            ra = pc + ((kind == 2'b00) ? 32'd6 : 32'd2);
            s1 = m_sp - 32'd8;
            s2 = s1 - 32'd4;
            push_exp(s1, 1'b1, ra, "R2/R3");
            push_exp(s2, 1'b1, m_fp, "R4");
            e_sp = s2; e_fp = s2; e_pc = tgt;
            e_tag = "R4/R5";
        end
        m_sp = e_sp; m_fp = e_fp; m_pc = e_pc;
        forever begin
            @(negedge clk);
            if (done) begin
                cmd_valid = 1'b0;
                break;
            end
            if (noise) begin
                // R10: these must not disturb the sequence in progress
                cmd_valid = 1'b1; cmd_kind = 2'(cyc % 3);
                cur_sp = 32'hDEAD_0000 + 32'(cyc); cur_fp = 32'hBEEF_0000; target = 32'h1234_5678;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        @(negedge clk);
    endtask

    initial begin
        m_sp = 32'h0000_1000; m_fp = 32'h0000_2000; m_pc = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_req === 1'b0, "R1", "mem_req", {31'd0, mem_req}, 32'd0);
        chk(done === 1'b0, "R1", "done", {31'd0, done}, 32'd0);
        chk(new_sp === 32'd0, "R1", "new_sp", new_sp, 32'd0);
        chk(new_fp === 32'd0, "R1", "new_fp", new_fp, 32'd0);
        chk(new_pc === 32'd0, "R1", "new_pc", new_pc, 32'd0);
        rst_n = 1'b1;
        mon_on = 1;
        @(negedge clk);

        // R2 R3 R4 R5: absolute call, then R6 R7 return round trip
        run_cmd(2'b00, 32'h0000_0400, 32'h0000_8000, 0);
        run_cmd(2'b10, 32'h0000_8010, 32'h0, 0);
        chk(m_pc === 32'h0000_0406, "R3", "round-trip pc", m_pc, 32'h0000_0406);
        chk(m_sp === 32'h0000_1000, "R7", "round-trip sp", m_sp, 32'h0000_1000);

        // R3 register form, nested calls, unwound by two returns
        run_cmd(2'b01, 32'h0000_0500, 32'h0000_9000, 0);
        run_cmd(2'b00, 32'h0000_9004, 32'h0000_A000, 1);
        run_cmd(2'b10, 32'h0000_A020, 32'h0, 1);
        chk(m_pc === 32'h0000_900A, "R7", "inner return pc", m_pc, 32'h0000_900A);
        run_cmd(2'b10, 32'h0000_9100, 32'h0, 0);
        chk(m_pc === 32'h0000_0502, "R3", "outer return pc", m_pc, 32'h0000_0502);

        // Boundary: stack wraps below address zero
        m_sp = 32'h0000_0004;
        run_cmd(2'b01, 32'hFFFF_FFFE, 32'h0000_0040, 1);
        run_cmd(2'b10, 32'h0000_0044, 32'h0, 0);
        chk(m_sp === 32'h0000_0004, "R7", "wrapped sp", m_sp, 32'h0000_0004);

        // R10: reserved kind is ignored
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'b11; cur_sp = 32'h5555_0000; cur_fp = 32'h6666_0000;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) begin
            @(negedge clk);
            chk(mem_req === 1'b0 && done === 1'b0, "R10", "reserved kind activity",
                {30'd0, mem_req, done}, 32'd0);
            chk(new_sp === m_sp, "R10", "reserved kind new_sp", new_sp, m_sp);
        end

        repeat (3) @(negedge clk);
        chk(q_addr.size() == 0, "R8", "pending accesses", 32'(q_addr.size()), 32'd0);
        finish_run();
    end
endmodule